// File: doc/BRIEF.md
# Stream-to-Memory Burst Writer

This engine takes transfer commands one at a time. Each command gives a start byte address, a byte count and an address-increment flag. For each command the engine accepts words from a streaming sink and stores them in memory through a memory-mapped write master that supports bursts. Incoming words are collected in an internal buffer that holds two bursts' worth of data. Writes leave the engine as bursts of a fixed configured length. The last burst of a command carries whatever is left.

An end-of-packet marker on the sink closes the current command early. Any words already buffered are then flushed as a final, possibly short, burst. When the last word of a command has been written, the engine reports a one-cycle status token. The token holds the byte count actually written and a flag that says whether the command ended on an end-of-packet marker. With the increment flag clear, every word goes to the same address. In that case each word is written as its own single-beat transfer, so that no burst implies a moving address.

Top module: `swe_burst_writer`

## Requirements
- R1: After reset, cmd_ready is 1 and snk_ready, wr_write and sts_valid are 0.
- R2: A command is taken only while cmd_ready is 1. cmd_ready stays 0 from the acceptance of a command until its status token has been issued.
- R3: In increment mode, every burst except the last of a command has wr_burstcount equal to BURST_MAX. wr_address and wr_burstcount stay fixed for all beats of a burst.
- R4: The last burst of a command in increment mode carries the N mod BURST_MAX remaining words, where N is the number of words accepted for that command. When that remainder is 0, the last burst is full size.
- R5: The buffer holds 2*BURST_MAX words. snk_ready is 0 whenever the buffer holds 2*BURST_MAX words that have not yet been written.
- R6: A burst of L beats is started only when at least L words of the command are already buffered. A full burst therefore waits for BURST_MAX buffered words, and a short last burst waits until every remaining word has arrived.
- R7: A sink word accepted with snk_eop=1 is the last word of the command. No further sink word is taken for that command. The buffered words are flushed, and the status token reports sts_eop=1.
- R8: With cmd_incr=0, every beat targets cmd_addr and has wr_burstcount=1.
- R9: After the last beat of a command, sts_valid pulses for exactly one cycle. sts_bytes equals the number of words written times DATA_W/8. sts_eop is 0 unless R7 applied.
- R10: In increment mode, a burst's wr_address is cmd_addr plus DATA_W/8 times the number of words the same command wrote before it. Burst data follows sink order.
- R11: While wr_write=1 and wr_waitrequest=1, the next cycle keeps wr_write=1 with the same wr_address, wr_data and wr_burstcount.
- R12: A command with cmd_bytes=0 produces no write and a status token with sts_bytes=0 and sts_eop=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Engine can accept a command |
| cmd_addr | input | ADDR_W | Start byte address, word aligned |
| cmd_bytes | input | LEN_W | Byte count, a multiple of DATA_W/8 |
| cmd_incr | input | 1 | 1: address advances per word; 0: fixed address |
| snk_valid | input | 1 | Sink word offered |
| snk_ready | output | 1 | Engine accepts the sink word |
| snk_data | input | DATA_W | Sink word |
| snk_eop | input | 1 | Sink word is the last of its packet |
| wr_address | output | ADDR_W | Burst start byte address |
| wr_write | output | 1 | Write beat valid |
| wr_data | output | DATA_W | Write beat data |
| wr_burstcount | output | $clog2(BURST_MAX+1) | Number of beats in the current burst |
| wr_waitrequest | input | 1 | Memory stalls the current beat |
| sts_valid | output | 1 | Status token valid, one cycle |
| sts_bytes | output | LEN_W | Bytes written for the finished command |
| sts_eop | output | 1 | Command ended on an end-of-packet marker |

## Verification
The assertions assume that cmd_bytes is a whole number of words and that cmd_addr is word aligned. They also assume that the memory side may hold wr_waitrequest high for any number of cycles but eventually releases it. The bench only issues commands whose byte counts are multiples of four and whose addresses are aligned. It varies sink validity and wait requests randomly, including a phase with heavy stalls that fills the buffer to its limit. End-of-packet markers are placed on the first word, on a middle word, on the exact last word, or not at all. The bench never marks a word that lies beyond a command's length.

// File: rtl/swe_pkg.sv
package swe_pkg;

    typedef enum logic [1:0] {
        INTAKE_IDLE  = 2'd0,
        INTAKE_FILL  = 2'd1,
        INTAKE_DRAIN = 2'd2
    } intake_state_e;

    typedef enum logic {
        BURST_WAIT = 1'b0,
        BURST_BEAT = 1'b1
    } burst_state_e;

    // Length of the next burst, or 0 when no burst may start yet.
    function automatic int unsigned burst_pick(input int unsigned avail,
                                               input int unsigned limit,
                                               input logic        last);
        if (avail >= limit)
            return limit;
        else if (last && avail != 0)
            return avail;
        else
            return 0;
    endfunction

endpackage

// File: rtl/swe_fifo.sv
module swe_fifo #(
    parameter int W     = 32,
    parameter int DEPTH = 8
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             push,
    input  logic [W-1:0]                     push_data,
    input  logic                             pop,
    output logic [W-1:0]                     head,
    output logic [$clog2(DEPTH+1)-1:0]       count,
    output logic                             full,
    output logic                             empty
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q;
    logic [CNT_W-1:0] count_q;

    function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (push)
            mem[wr_ptr_q] <= push_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
            count_q  <= '0;
        end else begin
            if (push)
                wr_ptr_q <= ptr_next(wr_ptr_q);
            if (pop)
                rd_ptr_q <= ptr_next(rd_ptr_q);
            case ({push, pop})
                2'b10:   count_q <= count_q + CNT_W'(1);
                2'b01:   count_q <= count_q - CNT_W'(1);
                default: count_q <= count_q;
            endcase
        end
    end

    assign head  = mem[rd_ptr_q];
    assign count = count_q;
    assign full  = (count_q == CNT_W'(DEPTH));
    assign empty = (count_q == '0);

    // R5: the buffer never accepts a word beyond its depth
    assert_no_overflow_R5: assert property (@(posedge clk) disable iff (rst)
        push |-> (32'(count_q) < DEPTH));

    // R6: data is never drained from an empty buffer
    assert_no_underflow_R6: assert property (@(posedge clk) disable iff (rst)
        pop |-> (count_q != '0));

endmodule

// File: rtl/swe_intake.sv
module swe_intake
    import swe_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int LEN_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [LEN_W-1:0]  cmd_bytes,
    input  logic              snk_valid,
    output logic              snk_ready,
    input  logic              snk_eop,
    input  logic              buf_full,
    input  logic              complete,
    output logic              push,
    output logic              load,
    output logic              drain,
    output logic              sts_valid,
    output logic [LEN_W-1:0]  sts_bytes,
    output logic              sts_eop
);
    localparam int BPW_LG = $clog2(DATA_W / 8);

    typedef struct packed {
        logic [LEN_W-1:0] left;
        logic [LEN_W-1:0] taken;
        logic             eop;
    } progress_t;

    typedef struct packed {
        logic             valid;
        logic [LEN_W-1:0] bytes;
        logic             eop;
    } status_t;

    intake_state_e    state_q;
    progress_t        prog_q;
    status_t          sts_q;
    logic [LEN_W-1:0] cmd_words;

    assign cmd_words = cmd_bytes >> BPW_LG;
    assign cmd_ready = (state_q == INTAKE_IDLE);
    assign snk_ready = (state_q == INTAKE_FILL) && !buf_full;
    assign push      = snk_valid && snk_ready;
    assign load      = cmd_valid && cmd_ready;
    assign drain     = (state_q == INTAKE_DRAIN);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= INTAKE_IDLE;
            prog_q  <= '0;
            sts_q   <= '0;
        end else begin
            sts_q.valid <= 1'b0;
            case (state_q)
                INTAKE_IDLE: begin
                    if (cmd_valid) begin
                        prog_q.left  <= cmd_words;
                        prog_q.taken <= '0;
                        prog_q.eop   <= 1'b0;
                        state_q      <= (cmd_words == '0) ? INTAKE_DRAIN : INTAKE_FILL;
                    end
                end
                INTAKE_FILL: begin
                    if (push) begin
                        prog_q.left  <= prog_q.left - LEN_W'(1);
                        prog_q.taken <= prog_q.taken + LEN_W'(1);
                        if (snk_eop)
                            prog_q.eop <= 1'b1;
                        if (snk_eop || prog_q.left == LEN_W'(1))
                            state_q <= INTAKE_DRAIN;
                    end
                end
                INTAKE_DRAIN: begin
                    if (complete) begin
                        sts_q.valid <= 1'b1;
                        sts_q.bytes <= prog_q.taken << BPW_LG;
                        sts_q.eop   <= prog_q.eop;
                        state_q     <= INTAKE_IDLE;
                    end
                end
                default: state_q <= INTAKE_IDLE;
            endcase
        end
    end

    assign sts_valid = sts_q.valid;
    assign sts_bytes = sts_q.bytes;
    assign sts_eop   = sts_q.eop;

    // R7: an end-of-packet word closes the sink for the command
    assert_eop_closes_sink_R7: assert property (@(posedge clk) disable iff (rst)
        (push && snk_eop) |=> !snk_ready);

    // R2: a newly accepted command blocks further commands
    assert_one_command_R2: assert property (@(posedge clk) disable iff (rst)
        load |=> !cmd_ready);

    // R9: the status token lasts a single cycle
    assert_status_pulse_R9: assert property (@(posedge clk) disable iff (rst)
        sts_valid |=> !sts_valid);

endmodule

// File: rtl/swe_burst_master.sv
module swe_burst_master
    import swe_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int DATA_W    = 32,
    parameter int BURST_MAX = 4,
    parameter int CNT_W     = 4,
    parameter int BC_W      = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_addr,
    input  logic              load_incr,
    input  logic              drain,
    input  logic [CNT_W-1:0]  buf_count,
    input  logic [DATA_W-1:0] buf_head,
    output logic              pop,
    output logic              idle,
    output logic [ADDR_W-1:0] wr_address,
    output logic              wr_write,
    output logic [DATA_W-1:0] wr_data,
    output logic [BC_W-1:0]   wr_burstcount,
    input  logic              wr_waitrequest
);
    localparam int BPW_LG = $clog2(DATA_W / 8);

    burst_state_e      state_q;
    logic              incr_q;
    logic [ADDR_W-1:0] run_addr_q;
    logic [ADDR_W-1:0] burst_addr_q;
    logic [BC_W-1:0]   len_q;
    logic [BC_W-1:0]   left_q;
    logic [BC_W-1:0]   limit;
    logic [BC_W-1:0]   pick;
    logic              start;

    assign limit = incr_q ? BC_W'(BURST_MAX) : BC_W'(1);
    assign pick  = BC_W'(burst_pick(32'(buf_count), 32'(limit), drain));
    assign start = (state_q == BURST_WAIT) && (pick != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q      <= BURST_WAIT;
            incr_q       <= 1'b0;
            run_addr_q   <= '0;
            burst_addr_q <= '0;
            len_q        <= '0;
            left_q       <= '0;
        end else begin
            case (state_q)
                BURST_WAIT: begin
                    if (start) begin
                        len_q        <= pick;
                        left_q       <= pick;
                        burst_addr_q <= run_addr_q;
                        if (incr_q)
                            run_addr_q <= run_addr_q + (ADDR_W'(pick) << BPW_LG);
                        state_q <= BURST_BEAT;
                    end
                end
                BURST_BEAT: begin
                    if (!wr_waitrequest) begin
                        left_q <= left_q - BC_W'(1);
                        if (left_q == BC_W'(1))
                            state_q <= BURST_WAIT;
                    end
                end
                default: state_q <= BURST_WAIT;
            endcase
            if (load) begin
                incr_q     <= load_incr;
                run_addr_q <= load_addr;
            end
        end
    end

    assign wr_write      = (state_q == BURST_BEAT);
    assign wr_address    = burst_addr_q;
    assign wr_data       = buf_head;
    assign wr_burstcount = len_q;
    assign pop           = wr_write && !wr_waitrequest;
    assign idle          = (state_q == BURST_WAIT);

    // R6: every beat still owed by the burst is already buffered
    assert_beats_buffered_R6: assert property (@(posedge clk) disable iff (rst)
        (state_q == BURST_BEAT) |-> (32'(buf_count) >= 32'(left_q)));

    // R11: a stalled beat is held unchanged
    assert_hold_under_wait_R11: assert property (@(posedge clk) disable iff (rst)
        (wr_write && wr_waitrequest) |=>
            (wr_write && $stable(wr_address) && $stable(wr_data) && $stable(wr_burstcount)));

    // R3: bursts begun before the command's data is complete are full size
    assert_full_burst_R3: assert property (@(posedge clk) disable iff (rst)
        (wr_write && !drain && incr_q) |-> (32'(wr_burstcount) == BURST_MAX));

    // R4: a burst never exceeds the limit and never is empty
    assert_burst_bounds_R4: assert property (@(posedge clk) disable iff (rst)
        wr_write |-> (wr_burstcount != '0 && 32'(wr_burstcount) <= BURST_MAX));

    // R8: fixed-address writes are single beats at the command address
    assert_fixed_single_R8: assert property (@(posedge clk) disable iff (rst)
        (wr_write && !incr_q) |-> (wr_burstcount == BC_W'(1) && wr_address == run_addr_q));

endmodule

// File: rtl/swe_burst_writer.sv
module swe_burst_writer
    import swe_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int DATA_W    = 32,
    parameter int LEN_W     = 16,
    parameter int BURST_MAX = 4,
    localparam int BUF_DEPTH = 2 * BURST_MAX,
    localparam int CNT_W     = $clog2(BUF_DEPTH + 1),
    localparam int BC_W      = $clog2(BURST_MAX + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [LEN_W-1:0]  cmd_bytes,
    input  logic              cmd_incr,
    input  logic              snk_valid,
    output logic              snk_ready,
    input  logic [DATA_W-1:0] snk_data,
    input  logic              snk_eop,
    output logic [ADDR_W-1:0] wr_address,
    output logic              wr_write,
    output logic [DATA_W-1:0] wr_data,
    output logic [BC_W-1:0]   wr_burstcount,
    input  logic              wr_waitrequest,
    output logic              sts_valid,
    output logic [LEN_W-1:0]  sts_bytes,
    output logic              sts_eop
);
    logic              push, pop, load, drain, complete;
    logic              buf_full, buf_empty, burst_idle;
    logic [CNT_W-1:0]  buf_count;
    logic [DATA_W-1:0] buf_head;

    assign complete = drain && buf_empty && burst_idle;

    swe_intake #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .LEN_W  (LEN_W)
    ) u_intake (
        .clk       (clk),
        .rst       (rst),
        .cmd_valid (cmd_valid),
        .cmd_ready (cmd_ready),
        .cmd_bytes (cmd_bytes),
        .snk_valid (snk_valid),
        .snk_ready (snk_ready),
        .snk_eop   (snk_eop),
        .buf_full  (buf_full),
        .complete  (complete),
        .push      (push),
        .load      (load),
        .drain     (drain),
        .sts_valid (sts_valid),
        .sts_bytes (sts_bytes),
        .sts_eop   (sts_eop)
    );

    swe_fifo #(
        .W     (DATA_W),
        .DEPTH (BUF_DEPTH)
    ) u_buffer (
        .clk       (clk),
        .rst       (rst),
        .push      (push),
        .push_data (snk_data),
        .pop       (pop),
        .head      (buf_head),
        .count     (buf_count),
        .full      (buf_full),
        .empty     (buf_empty)
    );

    swe_burst_master #(
        .ADDR_W    (ADDR_W),
        .DATA_W    (DATA_W),
        .BURST_MAX (BURST_MAX),
        .CNT_W     (CNT_W),
        .BC_W      (BC_W)
    ) u_master (
        .clk            (clk),
        .rst            (rst),
        .load           (load),
        .load_addr      (cmd_addr),
        .load_incr      (cmd_incr),
        .drain          (drain),
        .buf_count      (buf_count),
        .buf_head       (buf_head),
        .pop            (pop),
        .idle           (burst_idle),
        .wr_address     (wr_address),
        .wr_write       (wr_write),
        .wr_data        (wr_data),
        .wr_burstcount  (wr_burstcount),
        .wr_waitrequest (wr_waitrequest)
    );

    // R12: the buffer stays empty between commands
    assert_idle_empty_R12: assert property (@(posedge clk) disable iff (rst)
        cmd_ready |-> (buf_empty && !wr_write));

endmodule

// File: tb/swe_burst_writer_test.sv
module swe_burst_writer_test;
    localparam int CLK_PERIOD = 10;
    localparam int BURST      = 4;
    localparam int BPW        = 4;
    localparam int DEPTH      = 2 * BURST;
    localparam int WATCHDOG   = 150000;

    logic        clk = 1'b0;
    logic        rst;
    logic        cmd_valid, cmd_ready, cmd_incr;
    logic [31:0] cmd_addr;
    logic [15:0] cmd_bytes;
    logic        snk_valid, snk_ready, snk_eop;
    logic [31:0] snk_data;
    logic [31:0] wr_address, wr_data;
    logic        wr_write, wr_waitrequest;
    logic [2:0]  wr_burstcount;
    logic        sts_valid, sts_eop;
    logic [15:0] sts_bytes;

    always #(CLK_PERIOD / 2) clk = ~clk;

    swe_burst_writer uut (
        .clk(clk), .rst(rst),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_addr(cmd_addr),
        .cmd_bytes(cmd_bytes), .cmd_incr(cmd_incr),
        .snk_valid(snk_valid), .snk_ready(snk_ready), .snk_data(snk_data), .snk_eop(snk_eop),
        .wr_address(wr_address), .wr_write(wr_write), .wr_data(wr_data),
        .wr_burstcount(wr_burstcount), .wr_waitrequest(wr_waitrequest),
        .sts_valid(sts_valid), .sts_bytes(sts_bytes), .sts_eop(sts_eop)
    );

    typedef struct { logic [31:0] addr; logic [15:0] bytes; logic incr; } cmd_s;
    typedef struct { logic [31:0] data; logic eop; } word_s;
    typedef struct { logic [31:0] addr; int bc; logic [31:0] data; int id; bit first; bit fixed; } beat_s;
    typedef struct { int bytes; bit eop; int id; } sts_s;

    cmd_s  cmd_q[$];
    word_s snk_q[$];
    beat_s exp_q[$];
    sts_s  sts_q[$];

    int checks = 0, errors = 0, next_id = 0, outstanding = 0, occupancy = 0, cycle = 0;
    int sink_pct = 80, wait_pct = 20;
    bit hung = 0;
    bit hold_pend = 0;
    logic [31:0] hold_addr, hold_data;
    logic [2:0]  hold_bc;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Build the expected beats and status of one command from the requirements.
    task automatic issue(input logic [31:0] addr, input int bytes, input bit incr, input int eop_at);
        int words = bytes / BPW;
        int n = words;
        bit e = 0;
        int start = 0;
        logic [31:0] dq[$];
        if (eop_at >= 0 && eop_at < words) begin
            n = eop_at + 1;
            e = 1;
        end
        cmd_q.push_back('{addr, 16'(bytes), incr});
        for (int i = 0; i < n; i++) begin
            logic [31:0] d = $urandom;
            dq.push_back(d);
            snk_q.push_back('{d, e && (i == n - 1)});
        end
        while (start < n) begin
            int len = incr ? ((n - start) < BURST ? (n - start) : BURST) : 1;
            for (int j = 0; j < len; j++)
                exp_q.push_back('{incr ? addr + 32'(start * BPW) : addr, len,
                                  dq[start + j], next_id, j == 0, !incr});
            start += len;
        end
        sts_q.push_back('{n * BPW, e, next_id});
        next_id++;
    endtask

    task automatic tick();
        bit acc = 0;
        @(negedge clk);
        cycle++;
        if (sts_valid) begin
            if (sts_q.size() == 0) begin
                check(0, "R9", "unexpected status", 1, 0);
            end else begin
                sts_s s = sts_q.pop_front();
                string tag = (s.bytes == 0 && !s.eop) ? "R12" : (s.eop ? "R7" : "R9");
                check(sts_bytes == 16'(s.bytes), tag, "status bytes", longint'(sts_bytes), s.bytes);
                check(sts_eop == s.eop, tag, "status eop flag", longint'(sts_eop), longint'(s.eop));
                check(exp_q.size() == 0 || exp_q[0].id != s.id, "R9", "status before last beat",
                      exp_q.size(), 0);
            end
            outstanding = 0;
        end
        if (hold_pend) begin
            check(wr_write && wr_address == hold_addr && wr_data == hold_data &&
                  wr_burstcount == hold_bc, "R11", "stalled beat changed",
                  {wr_write, wr_address}, {1'b1, hold_addr});
        end
        cmd_valid = (cmd_q.size() > 0);
        if (cmd_q.size() > 0) begin
            cmd_addr  = cmd_q[0].addr;
            cmd_bytes = cmd_q[0].bytes;
            cmd_incr  = cmd_q[0].incr;
        end
        snk_valid = (snk_q.size() > 0) && (($urandom % 100) < sink_pct);
        if (snk_q.size() > 0) begin
            snk_data = snk_q[0].data;
            snk_eop  = snk_q[0].eop;
        end else begin
            snk_data = $urandom;
            snk_eop  = 1'b0;
        end
        wr_waitrequest = (($urandom % 100) < wait_pct);
        #1;
        if (cmd_valid && cmd_ready) begin
            check(outstanding == 0, "R2", "command taken before prior status", outstanding, 0);
            outstanding = 1;
            void'(cmd_q.pop_front());
        end
        if (snk_valid && snk_ready) begin
            check(occupancy < DEPTH, "R5", "sink accepted into full buffer", occupancy, DEPTH - 1);
            void'(snk_q.pop_front());
            acc = 1;
        end
        hold_pend = 0;
        if (wr_write) begin
            if (wr_waitrequest) begin
                hold_pend = 1;
                hold_addr = wr_address;
                hold_data = wr_data;
                hold_bc   = wr_burstcount;
            end else if (exp_q.size() == 0) begin
                check(0, "R12", "unexpected write beat", longint'(wr_address), 0);
            end else begin
                beat_s b = exp_q.pop_front();
                string tag = b.fixed ? "R8" : (b.bc == BURST ? "R3" : "R4");
                check(wr_address == b.addr, b.fixed ? "R8" : "R10", "beat address",
                      longint'(wr_address), longint'(b.addr));
                check(wr_data == b.data, "R10", "beat data", longint'(wr_data), longint'(b.data));
                check(int'(wr_burstcount) == b.bc, tag, "burst count",
                      longint'(wr_burstcount), b.bc);
                if (b.first)
                    check(occupancy >= b.bc, "R6", "burst began before its words buffered",
                          occupancy, b.bc);
                occupancy--;
            end
        end
        if (acc)
            occupancy++;
        if (cycle > WATCHDOG && !hung) begin
            hung = 1;
            checks++;
            errors++;
            $display("FAIL R9 watchdog: actual cycles %0d expected below %0d", cycle, WATCHDOG);
        end
    endtask

    task automatic drain_all();
        while (!hung && (cmd_q.size() > 0 || snk_q.size() > 0 || exp_q.size() > 0 ||
                         sts_q.size() > 0 || outstanding != 0))
            tick();
        repeat (5) tick();
    endtask

    initial begin
        rst = 1'b1;
        cmd_valid = 0; cmd_addr = '0; cmd_bytes = '0; cmd_incr = 0;
        snk_valid = 0; snk_data = '0; snk_eop = 0; wr_waitrequest = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        check(cmd_ready == 1'b1, "R1", "cmd_ready after reset", longint'(cmd_ready), 1);
        check(snk_ready == 1'b0, "R1", "snk_ready after reset", longint'(snk_ready), 0);
        check(wr_write == 1'b0, "R1", "wr_write after reset", longint'(wr_write), 0);
        check(sts_valid == 1'b0, "R1", "sts_valid after reset", longint'(sts_valid), 0);

        // R3 R4 R10: 10 words -> 4,4,2 ; 8 words -> 4,4 ; 3 words -> 3
        issue(32'h0000_1000, 40, 1, -1);
        issue(32'h0000_2000, 32, 1, -1);
        issue(32'h0000_3000, 12, 1, -1);
        drain_all();
        // R8: fixed address, single beats
        issue(32'h0000_4000, 20, 0, -1);
        drain_all();
        // R7: end-of-packet in the middle, at the first word, at the exact last word
        issue(32'h0000_5000, 64, 1, 5);
        issue(32'h0000_6000, 40, 1, 0);
        issue(32'h0000_7000, 16, 1, 3);
        issue(32'h0000_7800, 24, 0, 2);
        drain_all();
        // R12: zero-length command
        issue(32'h0000_8000, 0, 1, -1);
        drain_all();
        // R5 R11: heavy stalls with a fast sink fill the buffer
        sink_pct = 100;
        wait_pct = 75;
        issue(32'h0000_9000, 80, 1, -1);
        issue(32'h0000_A000, 36, 1, 7);
        drain_all();
        // mixed random commands
        sink_pct = 60;
        wait_pct = 30;
        for (int k = 0; k < 40; k++) begin
            int words = int'($urandom % 20);
            int eop_at = (($urandom % 3) == 0) ? int'($urandom % 24) : -1;
            issue({16'h0001, 16'($urandom) & 16'hFFFC}, words * BPW, bit'($urandom % 4 != 0), eop_at);
        end
        drain_all();
        check(exp_q.size() == 0 && sts_q.size() == 0, "R9", "work left over",
              exp_q.size() + sts_q.size(), 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule